// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interval Mask and Repeat Counter

This block watches a running calendar and raises an alarm when the calendar reaches a stored alarm time. The calendar counters sit outside the block. They present their current time as one packed BCD word, together with a one-clock update strobe each half second. A 4-bit interval code selects which calendar fields take part in the comparison. The available intervals run from every half second up to once a year.

An alarm event needs three things: the alarm is enabled, the update strobe is high, and the selected fields match. Each event produces a one-clock interrupt and toggles a square-wave output, so that output runs at half the event rate. An 8-bit repeat counter limits how many events occur. When it runs out, the block turns the alarm off by itself. In chime mode the counter wraps around instead, and the alarm repeats without end.

The alarm time can be written only while the alarm is off. The configuration word (enable, chime, interval code and repeat count) can be written at any time. A configuration write takes precedence over a simultaneous event.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_irq`, `alarm_pulse` and `alarm_en` are 0 and `repeat_left` is 00h.
- R2: `cal_time` and `time_wdata` share one packed BCD layout: bit 0 half-second, bits 7:1 seconds, bits 14:8 minutes, bits 20:15 hours, bits 23:21 weekday, bits 29:24 day of month, bits 34:30 month.
- R3: The interval codes select these fields for comparison. 0: none, so every update fires. 1: half-second. 2: adds the seconds ones digit (bits 4:1). 3: full seconds. 4: adds the minutes ones digit (bits 11:8). 5: full minutes. 6: adds hours. 7: adds weekday. 8: hours, minutes, seconds, half-second and day of month, with weekday ignored. 9: as 8 plus month.
- R4: Interval codes 10 to 15 never produce an event.
- R5: An event occurs only on a clock where `cal_tick` is high, the alarm is enabled and the selected fields match. A calendar value that is held without a strobe produces no event.
- R6: `alarm_irq` is high for exactly the one clock after each event edge.
- R7: Each event with a nonzero repeat count decrements `repeat_left` by one, and the alarm stays enabled.
- R8: An event with `repeat_left` at 00h and chime off is the last event, and `alarm_en` drops with it. Loading a count of 00h therefore gives exactly one event.
- R9: With chime on, an event at count 00h reloads FFh and the alarm stays enabled.
- R10: `alarm_pulse` toggles on every event and returns to 0 one clock after the alarm is off.
- R11: A `time_wr` while the alarm is enabled leaves the stored alarm time unchanged.
- R12: A `cfg_wr` loads enable, chime, interval code and count together, whatever the alarm state. The result is visible on `alarm_en` and `repeat_left` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_tick | input | 1 | One-clock strobe for each new calendar value |
| cal_time | input | 35 | Current calendar time, packed BCD (R2 layout) |
| time_wr | input | 1 | Alarm time write strobe |
| time_wdata | input | 35 | Alarm time to store, same layout |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Alarm enable value |
| cfg_chime | input | 1 | Endless repeat select |
| cfg_mask | input | 4 | Interval code |
| cfg_count | input | 8 | Repeat count to load |
| alarm_irq | output | 1 | One-clock interrupt per event |
| alarm_pulse | output | 1 | Square wave toggling on each event |
| alarm_en | output | 1 | Current enable state |
| repeat_left | output | 8 | Current repeat count |

## Verification
The interval codes are tried against a calendar value that equals the alarm time except in one chosen field. A pair of codes that differ by one field either fires or stays silent on that single difference, so each vector shows whether that field is in or out of the compared set. The weekday-versus-day vectors separate code 7 from code 8, and the reserved codes are run against an exact match to show they never fire. Sequences of consecutive strobes separate the finite countdown from the chime wrap and track the square wave. A write to the alarm time while enabled is tested against both the old time and the new one.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int TIME_W   = 35;
  localparam int MASK_W   = 4;
  localparam int RPT_W    = 8;
  localparam int MASK_MAX = 9;

  // Fields that take part in the comparison for each interval code.
  function automatic logic [TIME_W-1:0] mask_select(input logic [MASK_W-1:0] code);
    logic [TIME_W-1:0] sel;
    case (code)
      4'd1:    sel = 35'h0_0000_0001;
      4'd2:    sel = 35'h0_0000_001F;
      4'd3:    sel = 35'h0_0000_00FF;
      4'd4:    sel = 35'h0_0000_0FFF;
      4'd5:    sel = 35'h0_0000_7FFF;
      4'd6:    sel = 35'h0_001F_FFFF;
      4'd7:    sel = 35'h0_00FF_FFFF;
      4'd8:    sel = 35'h0_3F1F_FFFF;
      4'd9:    sel = 35'h7_FF1F_FFFF;
      default: sel = '0;
    endcase
    return sel;
  endfunction

  function automatic logic time_match(input logic [MASK_W-1:0] code,
                                      input logic [TIME_W-1:0] now,
                                      input logic [TIME_W-1:0] alm);
    if (int'(code) > MASK_MAX) return 1'b0;
    return ((now ^ alm) & mask_select(code)) == '0;
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              time_wr,
  input  logic [TIME_W-1:0] time_wdata,
  input  logic              en_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [TIME_W-1:0] cal_time,
  output logic              match_o
);
  logic [TIME_W-1:0] alm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                alm_q <= '0;
    else if (time_wr && !en_i) alm_q <= time_wdata;
  end

  assign match_o = time_match(mask_i, cal_time, alm_q);

  p_time_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable(alm_q));

  p_reserved_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(mask_i) > MASK_MAX) |-> !match_o);
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W = RPT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_chime,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              event_i,
  output logic              en_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = '1;

  logic             en_q, chime_q;
  logic [MASK_W-1:0] mask_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_zero, last_event, wrap_event;

  assign cnt_zero   = (cnt_q == '0);
  assign last_event = event_i && cnt_zero && !chime_q;
  assign wrap_event = event_i && cnt_zero && chime_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      chime_q <= 1'b0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else if (cfg_wr) begin
      en_q    <= cfg_en;
      chime_q <= cfg_chime;
      mask_q  <= cfg_mask;
      cnt_q   <= cfg_count;
    end else if (event_i) begin
      if (last_event)      en_q  <= 1'b0;
      else if (wrap_event) cnt_q <= CNT_FULL;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign cnt_o  = cnt_q;

  p_decrement_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i && !cnt_zero && !cfg_wr) |=> (cnt_q == $past(cnt_q) - 1'b1) && en_q);

  p_final_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_event && !cfg_wr) |=> !en_q);

  p_chime_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_event && !cfg_wr) |=> (cnt_q == CNT_FULL) && en_q);
endmodule

// File: rtl/rtc_alarm_out.sv
module rtc_alarm_out (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic en_i,
  output logic irq_o,
  output logic pulse_o
);
  logic irq_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      irq_q <= event_i;
      if (event_i)    pulse_q <= ~pulse_q;
      else if (!en_i) pulse_q <= 1'b0;
    end
  end

  assign irq_o   = irq_q;
  assign pulse_o = pulse_q;

  p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !event_i) |=> !pulse_q);

  p_pulse_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> (pulse_q != $past(pulse_q)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_tick,
  input  logic [TIME_W-1:0] cal_time,
  input  logic              time_wr,
  input  logic [TIME_W-1:0] time_wdata,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_chime,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [RPT_W-1:0]  cfg_count,
  output logic              alarm_irq,
  output logic              alarm_pulse,
  output logic              alarm_en,
  output logic [RPT_W-1:0]  repeat_left
);
  logic              fields_match;
  logic              alarm_event;
  logic              en_w;
  logic [MASK_W-1:0] mask_w;

  rtc_alarm_cmp u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .time_wr    (time_wr),
    .time_wdata (time_wdata),
    .en_i       (en_w),
    .mask_i     (mask_w),
    .cal_time   (cal_time),
    .match_o    (fields_match)
  );

  assign alarm_event = en_w && cal_tick && fields_match;

  rtc_alarm_ctrl #(.CNT_W(RPT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_en    (cfg_en),
    .cfg_chime (cfg_chime),
    .cfg_mask  (cfg_mask),
    .cfg_count (cfg_count),
    .event_i   (alarm_event),
    .en_o      (en_w),
    .mask_o    (mask_w),
    .cnt_o     (repeat_left)
  );

  rtc_alarm_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (alarm_event),
    .en_i    (en_w),
    .irq_o   (alarm_irq),
    .pulse_o (alarm_pulse)
  );

  assign alarm_en = en_w;

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(alarm_en) && $past(cal_tick));

  p_cfg_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (alarm_en == $past(cfg_en)) && (repeat_left == $past(cfg_count)));
endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_tick = 1'b0;
  logic [34:0] cal_time = '0;
  logic        time_wr = 1'b0;
  logic [34:0] time_wdata = '0;
  logic        cfg_wr = 1'b0, cfg_en = 1'b0, cfg_chime = 1'b0;
  logic [3:0]  cfg_mask = '0;
  logic [7:0]  cfg_count = '0;
  logic        alarm_irq, alarm_pulse, alarm_en;
  logic [7:0]  repeat_left;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rtc_alarm_match u_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .cal_tick(cal_tick), .cal_time(cal_time),
    .time_wr(time_wr), .time_wdata(time_wdata), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_chime(cfg_chime), .cfg_mask(cfg_mask), .cfg_count(cfg_count),
    .alarm_irq(alarm_irq), .alarm_pulse(alarm_pulse), .alarm_en(alarm_en),
    .repeat_left(repeat_left)
  );

  // R2 layout: {month, day, weekday, hour, minute, second, half}
  function automatic logic [34:0] pack_t(input logic h, input logic [6:0] s,
      input logic [6:0] mi, input logic [5:0] hr, input logic [2:0] wd,
      input logic [5:0] d, input logic [4:0] mo);
    return {mo, d, wd, hr, mi, s, h};
  endfunction

  // Base alarm time, and variants that differ from it in one field only.
  function automatic logic [34:0] variant(input int v);
    logic h = 1'b1; logic [6:0] s = 7'h35; logic [6:0] mi = 7'h42;
    logic [5:0] hr = 6'h17; logic [2:0] wd = 3'd3; logic [5:0] d = 6'h21;
    logic [4:0] mo = 5'h06;
    case (v)
      1: h  = 1'b0;
      2: s  = 7'h36;
      3: s  = 7'h45;
      4: mi = 7'h43;
      5: mi = 7'h52;
      6: hr = 6'h18;
      7: wd = 3'd4;
      8: d  = 6'h22;
      9: mo = 5'h07;
      default: ;
    endcase
    return pack_t(h, s, mi, hr, wd, d, mo);
  endfunction

  // {mask code, variant, expected event}; R3 and R4 vectors
  localparam logic [8:0] VEC [26] = '{
    {4'd0,4'd0,1'b1}, {4'd0,4'd9,1'b1}, {4'd1,4'd1,1'b0}, {4'd1,4'd2,1'b1},
    {4'd2,4'd2,1'b0}, {4'd2,4'd3,1'b1}, {4'd3,4'd3,1'b0}, {4'd3,4'd4,1'b1},
    {4'd4,4'd4,1'b0}, {4'd4,4'd5,1'b1}, {4'd5,4'd5,1'b0}, {4'd5,4'd6,1'b1},
    {4'd6,4'd6,1'b0}, {4'd6,4'd7,1'b1}, {4'd7,4'd7,1'b0}, {4'd7,4'd8,1'b1},
    {4'd8,4'd7,1'b1}, {4'd8,4'd8,1'b0}, {4'd8,4'd9,1'b1}, {4'd9,4'd9,1'b0},
    {4'd9,4'd8,1'b0}, {4'd9,4'd7,1'b1}, {4'd9,4'd0,1'b1}, {4'd12,4'd0,1'b0},
    {4'd15,4'd0,1'b0}, {4'd10,4'd0,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic en, input logic ch, input logic [3:0] m, input logic [7:0] c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_en = en; cfg_chime = ch; cfg_mask = m; cfg_count = c;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic twr(input logic [34:0] t);
    @(negedge clk);
    time_wr = 1'b1; time_wdata = t;
    @(negedge clk);
    time_wr = 1'b0;
  endtask

  // One strobe; returns sampled just after the edge that takes it.
  task automatic tick(input logic [34:0] t);
    @(negedge clk);
    cal_tick = 1'b1; cal_time = t;
    @(negedge clk);
    cal_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", alarm_irq, 0);
    chk("R1 pulse", alarm_pulse, 0);
    chk("R1 en", alarm_en, 0);
    chk("R1 count", repeat_left, 0);

    // Table: interval codes against single-field differences (R2, R3, R4)
    for (int i = 0; i < 26; i++) begin
      cfg(1'b0, 1'b0, 4'd0, 8'd0);
      twr(variant(0));
      cfg(1'b1, 1'b0, VEC[i][8:5], 8'd0);
      tick(variant(int'(VEC[i][4:1])));
      chk($sformatf("R3 R4 R2 vec%0d", i), alarm_irq, VEC[i][0]);
    end

    // R12 configuration readback
    cfg(1'b0, 1'b0, 4'd0, 8'd0);
    @(negedge clk);
    cfg(1'b1, 1'b0, 4'd15, 8'h5A);
    chk("R12 en", alarm_en, 1);
    chk("R12 count", repeat_left, 8'h5A);

    // R5 matching value held without a strobe
    cfg(1'b1, 1'b0, 4'd0, 8'd3);
    cal_time = variant(0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R5 no strobe", alarm_irq, 0);
    end
    chk("R5 count held", repeat_left, 3);

    // R7 R8 R10 finite countdown from 2
    cfg(1'b0, 1'b0, 4'd0, 8'd0);
    @(negedge clk);
    chk("R10 idle pulse", alarm_pulse, 0);
    cfg(1'b1, 1'b0, 4'd0, 8'd2);
    tick(variant(0));
    chk("R7 irq1", alarm_irq, 1);
    chk("R7 count1", repeat_left, 1);
    chk("R10 pulse1", alarm_pulse, 1);
    @(negedge clk);
    chk("R6 irq single", alarm_irq, 0);
    tick(variant(0));
    chk("R7 count2", repeat_left, 0);
    chk("R7 en kept", alarm_en, 1);
    chk("R10 pulse2", alarm_pulse, 0);
    tick(variant(0));
    chk("R8 irq last", alarm_irq, 1);
    chk("R8 en off", alarm_en, 0);
    chk("R10 pulse3", alarm_pulse, 1);
    @(negedge clk);
    chk("R10 pulse cleared", alarm_pulse, 0);
    tick(variant(0));
    chk("R8 no more", alarm_irq, 0);

    // R9 chime wrap
    cfg(1'b1, 1'b1, 4'd0, 8'd0);
    tick(variant(0));
    chk("R9 irq", alarm_irq, 1);
    chk("R9 wrap", repeat_left, 8'hFF);
    chk("R9 en", alarm_en, 1);
    tick(variant(0));
    chk("R9 next", repeat_left, 8'hFE);

    // R11 alarm time locked while enabled
    cfg(1'b0, 1'b0, 4'd0, 8'd0);
    twr(variant(0));
    cfg(1'b1, 1'b0, 4'd3, 8'd5);
    twr(pack_t(1'b1, 7'h10, 7'h42, 6'h17, 3'd3, 6'h21, 5'h06));
    tick(pack_t(1'b1, 7'h10, 7'h42, 6'h17, 3'd3, 6'h21, 5'h06));
    chk("R11 new time ignored", alarm_irq, 0);
    tick(variant(0));
    chk("R11 old time kept", alarm_irq, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule